// File: doc/BRIEF.md
# Stuck Control-Line Monitor for a Bus Transmitter

This block watches two control lines of a bus transmitter while the device runs in its normal operating mode. The first line is an active-low transmit enable. The second is an active-high bus-guardian enable. If either line stays at its active level for too long, the block records a clamped-line fault in a sticky flag.

A clamped transmit enable is treated as dangerous. It raises a transmitter-disable output that keeps the driver off the bus. A clamped guardian enable is only recorded. Its flag has no effect on transmission. Each line has its own cycle-count threshold, set by a parameter.

Detection runs only in normal mode. Leaving that mode, or letting the line return to its idle level, restarts the count for that line. A single clear strobe drops both flags. The disable is lifted only once the transmit enable has returned high and its flag has been cleared.

Top module: `clamp_monitor`

## Requirements
- R1: During and right after reset, `txClampFlag`, `guardClampFlag` and `txDisable` are all 0.
- R2: `txClampFlag` goes to 1 on the clock edge at which `txEnN` has been sampled 0 with `normalMode` 1 (and `clearFlags` 0) for `TX_LIMIT` consecutive edges, and not one edge earlier.
- R3: `guardClampFlag` goes to 1 on the clock edge at which `guardEn` has been sampled 1 with `normalMode` 1 (and `clearFlags` 0) for `GUARD_LIMIT` consecutive edges, and not one edge earlier.
- R4: A single sampled cycle with the line at its idle level (`txEnN` 1, `guardEn` 0), or with `normalMode` 0, resets that line's count. A full new threshold is then needed.
- R5: While `normalMode` is 0, neither flag is ever set, however long a line stays active.
- R6: `txDisable` goes to 1 on the same edge as `txClampFlag` rises.
- R7: Setting `guardClampFlag` leaves `txDisable` unchanged.
- R8: Both flags are sticky. They drop only on reset or on an edge with `clearFlags` sampled 1, and that edge clears both of them.
- R9: Once asserted, `txDisable` falls only on an edge where `txEnN` is sampled 1 and the transmit flag is already 0 or `clearFlags` is sampled 1. It stays 1 while `txEnN` remains 0, even after the flag is cleared.
- R10: If a line is still active when a clear is sampled, its flag sets again only after `TX_LIMIT` (or `GUARD_LIMIT`) further qualifying edges after the clear edge.
- R11: The counts saturate at their threshold. A line held active for many times its threshold keeps its flag at a steady 1 with no glitch back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnN | input | 1 | Transmit enable, active low |
| guardEn | input | 1 | Bus-guardian enable, active high |
| normalMode | input | 1 | High while the device is in normal mode |
| clearFlags | input | 1 | One-cycle strobe that clears both flags |
| txClampFlag | output | 1 | Sticky flag: transmit enable clamped low |
| guardClampFlag | output | 1 | Sticky flag: guardian enable clamped high |
| txDisable | output | 1 | Forces the transmitter off |

## Verification
The bench targets the exact threshold edge. A design that was off by one would raise a flag one cycle early or late, or would never fire when the line is held for exactly the limit.

It places a one-cycle gap in an active run, and it leaves and re-enters normal mode mid-run. A design that paused the count instead of restarting it would flag too soon.

It clears a flag while the line is still active. A design that kept its count across the clear would re-flag at once. A design that released the disable at the clear would let a still-clamped transmit enable drive the bus.

Long holds check saturation, since a wrapping count would make the flag blink. Random traffic in and out of normal mode checks that the guardian fault never touches the disable.

// File: rtl/clamp_monitor_pkg.sv
package clamp_monitor_pkg;

  // Commands from control to the duration timers
  typedef struct packed {
    logic txZero;
    logic txCount;
    logic guardZero;
    logic guardCount;
  } timerCmd_t;

  // Threshold strobes from the timers back to control
  typedef struct packed {
    logic txHit;
    logic guardHit;
  } timerHit_t;

endpackage

// File: rtl/clamp_timer.sv
module clamp_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic zero,
  input  logic count,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  localparam logic [CW-1:0] PRE = CW'(LIMIT - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= '0;
    end else if (zero) begin
      run <= '0;
    end else if (count && (run != TOP)) begin
      run <= run + 1'b1;
    end
  end

  // Fires on the edge that brings the run up to the limit
  assign hit = count && !zero && (run == PRE);

endmodule

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_monitor_pkg::*;
#(
  parameter int TX_LIMIT    = 16,
  parameter int GUARD_LIMIT = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output timerHit_t hits
);
  localparam int NCH = 2;

  logic [NCH-1:0] zeroVec;
  logic [NCH-1:0] countVec;
  logic [NCH-1:0] hitVec;

  assign zeroVec  = {cmd.guardZero, cmd.txZero};
  assign countVec = {cmd.guardCount, cmd.txCount};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam int LIM = (ch == 0) ? TX_LIMIT : GUARD_LIMIT;
    clamp_timer #(.LIMIT(LIM)) u_timer (
      .clk  (clk),
      .rstN (rstN),
      .zero (zeroVec[ch]),
      .count(countVec[ch]),
      .hit  (hitVec[ch])
    );
  end

  assign hits.txHit    = hitVec[0];
  assign hits.guardHit = hitVec[1];

endmodule

// File: rtl/clamp_control.sv
module clamp_control
  import clamp_monitor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnN,
  input  logic      guardEn,
  input  logic      normalMode,
  input  logic      clearFlags,
  input  timerHit_t hits,
  output timerCmd_t cmd,
  output logic      txFlag,
  output logic      guardFlag,
  output logic      txOff
);
  logic txActive;
  logic guardActive;
  logic txRelease;

  assign txActive    = normalMode && !txEnN;
  assign guardActive = normalMode && guardEn;

  always_comb begin
    cmd.txCount    = txActive;
    cmd.txZero     = clearFlags || !txActive;
    cmd.guardCount = guardActive;
    cmd.guardZero  = clearFlags || !guardActive;
  end

  assign txRelease = txEnN && (clearFlags || !txFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag    <= 1'b0;
      guardFlag <= 1'b0;
      txOff     <= 1'b0;
    end else begin
      if (clearFlags)        txFlag <= 1'b0;
      else if (hits.txHit)   txFlag <= 1'b1;

      if (clearFlags)         guardFlag <= 1'b0;
      else if (hits.guardHit) guardFlag <= 1'b1;

      if (hits.txHit)                txOff <= 1'b1;
      else if (txOff && txRelease)   txOff <= 1'b0;
    end
  end

endmodule

// File: rtl/clamp_monitor.sv
module clamp_monitor
  import clamp_monitor_pkg::*;
#(
  parameter int TX_LIMIT    = 16,
  parameter int GUARD_LIMIT = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic txEnN,
  input  logic guardEn,
  input  logic normalMode,
  input  logic clearFlags,
  output logic txClampFlag,
  output logic guardClampFlag,
  output logic txDisable
);
  timerCmd_t cmd;
  timerHit_t hits;

  clamp_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnN     (txEnN),
    .guardEn   (guardEn),
    .normalMode(normalMode),
    .clearFlags(clearFlags),
    .hits      (hits),
    .cmd       (cmd),
    .txFlag    (txClampFlag),
    .guardFlag (guardClampFlag),
    .txOff     (txDisable)
  );

  clamp_datapath #(
    .TX_LIMIT   (TX_LIMIT),
    .GUARD_LIMIT(GUARD_LIMIT)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .cmd (cmd),
    .hits(hits)
  );

endmodule

// File: rtl/clamp_monitor_checker.sv
module clamp_monitor_checker #(
  parameter int TX_LIMIT    = 16,
  parameter int GUARD_LIMIT = 24
) (
  input logic clk,
  input logic rstN,
  input logic txEnN,
  input logic guardEn,
  input logic normalMode,
  input logic clearFlags,
  input logic txClampFlag,
  input logic guardClampFlag,
  input logic txDisable
);
  localparam int TW = $clog2(TX_LIMIT + 1);
  localparam int GW = $clog2(GUARD_LIMIT + 1);

  logic [TW-1:0] txRun;
  logic [GW-1:0] guardRun;

  // Independent run-length counters used to bound the detection window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRun    <= '0;
      guardRun <= '0;
    end else begin
      if (clearFlags || !normalMode || txEnN) txRun <= '0;
      else if (txRun != TW'(TX_LIMIT))        txRun <= txRun + 1'b1;
      if (clearFlags || !normalMode || !guardEn) guardRun <= '0;
      else if (guardRun != GW'(GUARD_LIMIT))     guardRun <= guardRun + 1'b1;
    end
  end

  a_r2_tx_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txClampFlag) |-> (txRun == TW'(TX_LIMIT)));

  a_r3_guard_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardClampFlag) |-> (guardRun == GW'(GUARD_LIMIT)));

  a_r5_tx_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txClampFlag) |-> $past(normalMode && !txEnN));

  a_r5_guard_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(guardClampFlag) |-> $past(normalMode && guardEn));

  a_r6_flag_implies_off: assert property (@(posedge clk) disable iff (!rstN)
    txClampFlag |-> txDisable);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags |=> (!txClampFlag && !guardClampFlag));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txClampFlag && !clearFlags) |=> txClampFlag);

  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDisable) |-> $past(txEnN));

endmodule

bind clamp_monitor clamp_monitor_checker #(
  .TX_LIMIT   (TX_LIMIT),
  .GUARD_LIMIT(GUARD_LIMIT)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .txEnN         (txEnN),
  .guardEn       (guardEn),
  .normalMode    (normalMode),
  .clearFlags    (clearFlags),
  .txClampFlag   (txClampFlag),
  .guardClampFlag(guardClampFlag),
  .txDisable     (txDisable)
);

// File: tb/clamp_monitor_bench.sv
module clamp_monitor_bench;
  localparam int TXL = 16;
  localparam int GL  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnN = 1'b1;
  logic guardEn = 1'b0;
  logic normalMode = 1'b0;
  logic clearFlags = 1'b0;
  logic txClampFlag, guardClampFlag, txDisable;

  int checks = 0;
  int fails = 0;

  // Reference state built from the requirements
  int   mTxRun = 0;
  int   mGRun = 0;
  logic mTxFlag = 1'b0;
  logic mGFlag = 1'b0;
  logic mDis = 1'b0;

  always #10 clk = ~clk;

  clamp_monitor #(.TX_LIMIT(TXL), .GUARD_LIMIT(GL)) u_clamp_monitor (
    .clk(clk), .rstN(rstN), .txEnN(txEnN), .guardEn(guardEn),
    .normalMode(normalMode), .clearFlags(clearFlags),
    .txClampFlag(txClampFlag), .guardClampFlag(guardClampFlag),
    .txDisable(txDisable)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic releaseOk(logic dis, logic enN, logic clr, logic flg);
    return dis && enN && (clr || !flg);
  endfunction

  task automatic modelEdge();
    logic oldTx, txSet, gSet;
    oldTx = mTxFlag;
    txSet = 1'b0;
    gSet  = 1'b0;
    if (clearFlags || !(normalMode && !txEnN)) mTxRun = 0;
    else if (mTxRun < TXL) begin
      mTxRun++;
      if (mTxRun == TXL) txSet = 1'b1;
    end
    if (clearFlags || !(normalMode && guardEn)) mGRun = 0;
    else if (mGRun < GL) begin
      mGRun++;
      if (mGRun == GL) gSet = 1'b1;
    end
    if (clearFlags) begin mTxFlag = 1'b0; mGFlag = 1'b0; end
    if (txSet) mTxFlag = 1'b1;
    if (gSet) mGFlag = 1'b1;
    if (txSet) mDis = 1'b1;
    else if (releaseOk(mDis, txEnN, clearFlags, oldTx)) mDis = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    #1;
    check("R2 model txClampFlag", txClampFlag, mTxFlag);
    check("R3 model guardClampFlag", guardClampFlag, mGFlag);
    check("R6 model txDisable", txDisable, mDis);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulseClear();
    clearFlags = 1'b1;
    step();
    clearFlags = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset txClampFlag", txClampFlag, 1'b0);
    check("R1 reset guardClampFlag", guardClampFlag, 1'b0);
    check("R1 reset txDisable", txDisable, 1'b0);
    rstN = 1'b1;
    normalMode = 1'b1;
    step();
    check("R1 after reset txDisable", txDisable, 1'b0);

    // R2 / R6: exact threshold
    txEnN = 1'b0;
    steps(TXL - 1);
    check("R2 not early", txClampFlag, 1'b0);
    step();
    check("R2 at limit", txClampFlag, 1'b1);
    check("R6 disable with flag", txDisable, 1'b1);

    // R11: long hold stays steady
    for (int i = 0; i < 3 * TXL + 5; i++) begin
      step();
      check("R11 saturated flag steady", txClampFlag, 1'b1);
    end

    // R9 / R10: clear while still clamped
    pulseClear();
    check("R8 clear drops flag", txClampFlag, 1'b0);
    check("R9 disable held while txEnN low", txDisable, 1'b1);
    steps(TXL - 1);
    check("R10 no early re-set", txClampFlag, 1'b0);
    step();
    check("R10 re-set after full window", txClampFlag, 1'b1);
    txEnN = 1'b1;
    step();
    check("R9 held while flag set", txDisable, 1'b1);
    check("R8 sticky", txClampFlag, 1'b1);
    pulseClear();
    check("R9 released on clear with txEnN high", txDisable, 1'b0);

    // R3 / R7: guardian fault only records
    guardEn = 1'b1;
    steps(GL - 1);
    check("R3 not early", guardClampFlag, 1'b0);
    step();
    check("R3 at limit", guardClampFlag, 1'b1);
    check("R7 no disable from guardian", txDisable, 1'b0);
    guardEn = 1'b0;
    steps(4);
    check("R8 guard flag sticky", guardClampFlag, 1'b1);
    pulseClear();
    check("R8 clear drops guard flag", guardClampFlag, 1'b0);

    // R4: one idle cycle restarts count
    txEnN = 1'b0;
    steps(TXL - 1);
    txEnN = 1'b1;
    step();
    txEnN = 1'b0;
    steps(TXL - 1);
    check("R4 gap restarts count", txClampFlag, 1'b0);
    step();
    check("R4 full window after gap", txClampFlag, 1'b1);
    txEnN = 1'b1;
    pulseClear();
    check("R9 disable dropped", txDisable, 1'b0);

    // R5: no detection outside normal mode, R4 re-entry restarts
    normalMode = 1'b0;
    txEnN = 1'b0;
    guardEn = 1'b1;
    steps(3 * GL);
    check("R5 tx gated", txClampFlag, 1'b0);
    check("R5 guard gated", guardClampFlag, 1'b0);
    normalMode = 1'b1;
    steps(TXL - 1);
    check("R4 re-entry tx not early", txClampFlag, 1'b0);
    step();
    check("R4 re-entry tx at limit", txClampFlag, 1'b1);
    steps(GL - TXL - 1);
    check("R4 re-entry guard not early", guardClampFlag, 1'b0);
    step();
    check("R4 re-entry guard at limit", guardClampFlag, 1'b1);
    txEnN = 1'b1;
    guardEn = 1'b0;
    pulseClear();

    // Random traffic against the reference
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 19) == 0) txEnN = ~txEnN;
      if ($urandom_range(0, 23) == 0) guardEn = ~guardEn;
      if ($urandom_range(0, 199) == 0) normalMode = ~normalMode;
      clearFlags = ($urandom_range(0, 59) == 0);
      step();
    end
    clearFlags = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule